// File: doc/BRIEF.md
# In-line ECC Command Sequencer

This block sits in front of a DRAM command queue and turns word-addressed user reads and writes into bank, row and column commands. The parity bits for each data word live in the same DRAM as the data, in a reserved region. For every request the block derives the location of the parity word that covers it. When that location differs from the one currently held, the block inserts an extra command for the parity word ahead of the user command. Eight consecutive data words share one parity word, so sequential traffic pays one extra command per eight data commands.

The flat word address is split so that banks alternate only in pairs. As a result the top of the address space, which is kept for parity, falls only in the upper rows of banks 6 and 7. Data in an even bank keeps its parity in bank 7, and data in an odd bank keeps it in bank 6, so a bank never holds its own parity. The block remembers the last parity location, whether a parity word is waiting to be written back, and whether the parity word for reads has been loaded. A flush input forces any waiting parity word out to DRAM. The block does not handle DRAM timing, refresh or the physical interface.

Top module: `inline_ecc_sequencer`

## Requirements
- R1: The user word address is split, from most to least significant bit, into bank[2:1], row (ROW_W bits), bank[0], and a word column of COL_W-3 bits. On a user command, cmd_bank is {bank[2:1], bank[0]}, cmd_row is the row field and cmd_col is the word column times 8 (three zero bits appended).
- R2: The bank of a parity command is {2'b11, ~bank[0]} of the request it serves. Even data banks map to bank 7 and odd data banks map to bank 6.
- R3: The row of a parity command is {1'b1, row[ROW_W-1:1]}, so data row 0 maps to parity row 16'h8000 at the default width.
- R4: The column of a parity command is {row[0], bank[2:1], word_column[COL_W-4:3], 3'b000}. Data words 0 to 7 (columns 0 to 56) share parity column 0, and words 8 to 15 (columns 64 to 120) share parity column 8. A user command carries cmd_slot = word_column[2:0]. A parity command carries cmd_slot = 0.
- R5: Suppose a parity write is pending and a user write arrives whose parity location differs from the held one. The block first issues an overhead write (cmd_overhead=1, cmd_write=1) to the held location. It then issues the user write.
- R6: A user read whose parity word is not loaded causes an overhead read (cmd_overhead=1, cmd_write=0) to the read's parity location before the data read. Sequential reads therefore see one overhead read per eight reads.
- R7: Suppose a read targets the parity location that is pending a write and has not been loaded. The pending word is first written back, then read, then the data read is issued.
- R8: While flush is high and a parity write is pending, the block issues an overhead write to the held location. With nothing pending, flush produces no command.
- R9: req_ready is low whenever an overhead command is presented. Otherwise req_ready equals cmd_ready.
- R10: After reset nothing is pending or loaded. No command is presented without a request or flush, the first write issues no overhead write, and the first read issues an overhead read.
- R11: A user command passes through with cmd_valid = req_valid, cmd_write = req_write and cmd_overhead = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | User request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat user word address |
| flush | input | 1 | Force write-back of a pending parity word |
| cmd_valid | output | 1 | Command presented to the queue |
| cmd_ready | input | 1 | Queue accepts the command |
| cmd_write | output | 1 | Command is a write |
| cmd_overhead | output | 1 | Command moves a parity word |
| cmd_bank | output | 3 | DRAM bank |
| cmd_row | output | ROW_W | DRAM row |
| cmd_col | output | COL_W | DRAM column, burst aligned |
| cmd_slot | output | 3 | Parity slot of a user command |

## Verification
On every cycle the assertions check four properties at the ports. Parity commands land only in banks 6 and 7 and in the upper row half. Any overhead command holds off the request port. User commands pass through unchanged, and nothing appears without a request or a flush. They also check that an accepted parity write or read is not repeated on the next cycle for the same request. The exact address arithmetic is shown only by the bench's scenarios: the pair-interleaved split, the parity column packing, and the order of the write-back, the reload and the data command when the parity location changes. The same holds for behaviour that spans several requests: one overhead command per eight sequential words, and a flush that does nothing when no parity word is pending.

// File: rtl/inline_ecc_seq_pkg.sv
package inline_ecc_seq_pkg;
   localparam int BANK_W = 3;
   localparam int SLOT_W = 3;

   typedef enum logic [1:0] {
      SRC_USER   = 2'd0,
      SRC_PAR_WR = 2'd1,
      SRC_PAR_RD = 2'd2
   } cmd_src_e;
endpackage

// File: rtl/iecc_addr_map.sv
module iecc_addr_map
   import inline_ecc_seq_pkg::*;
#(
   parameter int ROW_W = 16,
   parameter int COL_W = 10,
   localparam int WCOL_W = COL_W - 3,
   localparam int ADDR_W = ROW_W + COL_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic [BANK_W-1:0] pbank,
   output logic [ROW_W-1:0]  prow,
   output logic [COL_W-1:0]  pcol,
   output logic [SLOT_W-1:0] slot
);
   generate
      if (COL_W < 7) begin : g_bad_col
         $error("iecc_addr_map: COL_W must be at least 7");
      end
      if (ROW_W < 2) begin : g_bad_row
         $error("iecc_addr_map: ROW_W must be at least 2");
      end
   endgenerate

   logic [WCOL_W-1:0] wcol;
   logic              bank_lo;
   logic [1:0]        bank_hi;

   always_comb begin
      wcol    = addr[WCOL_W-1:0];
      bank_lo = addr[WCOL_W];
      row     = addr[WCOL_W+ROW_W:WCOL_W+1];
      bank_hi = addr[ADDR_W-1:ADDR_W-2];
      bank    = {bank_hi, bank_lo};
      col     = {wcol, 3'b000};
      pbank   = {2'b11, ~bank_lo};
      prow    = {1'b1, row[ROW_W-1:1]};
      pcol    = {row[0], bank_hi, wcol[WCOL_W-1:3], 3'b000};
      slot    = wcol[2:0];
   end
endmodule

// File: rtl/iecc_parity_state.sv
module iecc_parity_state
   import inline_ecc_seq_pkg::*;
#(
   parameter int ROW_W = 16,
   parameter int COL_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  cmd_src_e          src,
   input  logic              user_wr,
   input  logic [BANK_W-1:0] new_bank,
   input  logic [ROW_W-1:0]  new_row,
   input  logic [COL_W-1:0]  new_col,
   output logic              pend,
   output logic              loaded,
   output logic [BANK_W-1:0] key_bank,
   output logic [ROW_W-1:0]  key_row,
   output logic [COL_W-1:0]  key_col
);
   logic key_moves;

   always_comb begin
      key_moves = {key_bank, key_row, key_col} != {new_bank, new_row, new_col};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         loaded   <= 1'b0;
         key_bank <= '0;
         key_row  <= '0;
         key_col  <= '0;
      end else if (fire) begin
         case (src)
            SRC_PAR_WR: pend <= 1'b0;
            SRC_PAR_RD: begin
               loaded   <= 1'b1;
               key_bank <= new_bank;
               key_row  <= new_row;
               key_col  <= new_col;
            end
            default: begin
               if (user_wr) begin
                  pend     <= 1'b1;
                  key_bank <= new_bank;
                  key_row  <= new_row;
                  key_col  <= new_col;
                  if (key_moves) loaded <= 1'b0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/iecc_cmd_select.sv
module iecc_cmd_select
   import inline_ecc_seq_pkg::*;
#(
   parameter int ROW_W = 16,
   parameter int COL_W = 10
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              flush,
   input  logic              cmd_ready,
   input  logic              pend,
   input  logic              loaded,
   input  logic [BANK_W-1:0] key_bank,
   input  logic [ROW_W-1:0]  key_row,
   input  logic [COL_W-1:0]  key_col,
   input  logic [BANK_W-1:0] d_bank,
   input  logic [ROW_W-1:0]  d_row,
   input  logic [COL_W-1:0]  d_col,
   input  logic [SLOT_W-1:0] d_slot,
   input  logic [BANK_W-1:0] p_bank,
   input  logic [ROW_W-1:0]  p_row,
   input  logic [COL_W-1:0]  p_col,
   output cmd_src_e          src,
   output logic              fire,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic              cmd_write,
   output logic              cmd_overhead,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [SLOT_W-1:0] cmd_slot
);
   logic same_key, need_wb, need_load;

   always_comb begin
      same_key  = {key_bank, key_row, key_col} == {p_bank, p_row, p_col};
      need_wb   = pend && (flush ||
                  (req_valid && (!same_key || (!req_write && !loaded))));
      need_load = !need_wb && req_valid && !req_write && !(loaded && same_key);

      if (need_wb)        src = SRC_PAR_WR;
      else if (need_load) src = SRC_PAR_RD;
      else                src = SRC_USER;

      cmd_valid    = need_wb || need_load || req_valid;
      req_ready    = cmd_ready && !need_wb && !need_load;
      fire         = cmd_valid && cmd_ready;
      cmd_overhead = need_wb || need_load;

      case (src)
         SRC_PAR_WR: begin
            cmd_write = 1'b1;
            cmd_bank  = key_bank;
            cmd_row   = key_row;
            cmd_col   = key_col;
            cmd_slot  = '0;
         end
         SRC_PAR_RD: begin
            cmd_write = 1'b0;
            cmd_bank  = p_bank;
            cmd_row   = p_row;
            cmd_col   = p_col;
            cmd_slot  = '0;
         end
         default: begin
            cmd_write = req_write;
            cmd_bank  = d_bank;
            cmd_row   = d_row;
            cmd_col   = d_col;
            cmd_slot  = d_slot;
         end
      endcase
   end
endmodule

// File: rtl/inline_ecc_sequencer.sv
module inline_ecc_sequencer
   import inline_ecc_seq_pkg::*;
#(
   parameter int ROW_W = 16,
   parameter int COL_W = 10,
   localparam int ADDR_W = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              flush,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic              cmd_write,
   output logic              cmd_overhead,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [SLOT_W-1:0] cmd_slot
);
   logic [BANK_W-1:0] d_bank, p_bank, key_bank;
   logic [ROW_W-1:0]  d_row, p_row, key_row;
   logic [COL_W-1:0]  d_col, p_col, key_col;
   logic [SLOT_W-1:0] d_slot;
   logic              pend, loaded, fire;
   cmd_src_e          src;

   iecc_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W)) u_map (
      .addr (req_addr),
      .bank (d_bank), .row (d_row), .col (d_col),
      .pbank(p_bank), .prow(p_row), .pcol(p_col),
      .slot (d_slot)
   );

   iecc_parity_state #(.ROW_W(ROW_W), .COL_W(COL_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .src     (src),
      .user_wr (req_write),
      .new_bank(p_bank),
      .new_row (p_row),
      .new_col (p_col),
      .pend    (pend),
      .loaded  (loaded),
      .key_bank(key_bank),
      .key_row (key_row),
      .key_col (key_col)
   );

   iecc_cmd_select #(.ROW_W(ROW_W), .COL_W(COL_W)) u_sel (
      .req_valid   (req_valid),
      .req_write   (req_write),
      .flush       (flush),
      .cmd_ready   (cmd_ready),
      .pend        (pend),
      .loaded      (loaded),
      .key_bank    (key_bank),
      .key_row     (key_row),
      .key_col     (key_col),
      .d_bank      (d_bank),
      .d_row       (d_row),
      .d_col       (d_col),
      .d_slot      (d_slot),
      .p_bank      (p_bank),
      .p_row       (p_row),
      .p_col       (p_col),
      .src         (src),
      .fire        (fire),
      .req_ready   (req_ready),
      .cmd_valid   (cmd_valid),
      .cmd_write   (cmd_write),
      .cmd_overhead(cmd_overhead),
      .cmd_bank    (cmd_bank),
      .cmd_row     (cmd_row),
      .cmd_col     (cmd_col),
      .cmd_slot    (cmd_slot)
   );
endmodule

// File: rtl/inline_ecc_sequencer_chk.sv
module inline_ecc_sequencer_chk #(
   parameter int ROW_W = 16,
   parameter int COL_W = 10,
   localparam int ADDR_W = ROW_W + COL_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              flush,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              cmd_write,
   input logic              cmd_overhead,
   input logic [2:0]        cmd_bank,
   input logic [ROW_W-1:0]  cmd_row
);
   a_r9_overhead_holds_request: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_overhead) |-> !req_ready);

   a_r11_user_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (cmd_valid && !cmd_overhead && cmd_write == req_write));

   a_r2_parity_top_banks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_overhead) |-> (cmd_bank[2:1] == 2'b11));

   a_r3_parity_upper_rows: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_overhead) |-> cmd_row[ROW_W-1]);

   a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !flush) |-> !cmd_valid);

   a_r5_single_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_overhead && cmd_write)
      |=> !(cmd_valid && cmd_overhead && cmd_write));

   a_r6_single_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_overhead && !cmd_write && req_valid && !req_write)
      |=> !(req_valid && !req_write && $stable(req_addr) && cmd_valid && cmd_overhead));
endmodule

bind inline_ecc_sequencer inline_ecc_sequencer_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .flush       (flush),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_write   (cmd_write),
   .cmd_overhead(cmd_overhead),
   .cmd_bank    (cmd_bank),
   .cmd_row     (cmd_row)
);

// File: tb/inline_ecc_sequencer_tb.sv
`timescale 1ns/1ps
module inline_ecc_sequencer_tb;
   localparam int ROW_W  = 16;
   localparam int COL_W  = 10;
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int WCN    = 1 << (COL_W - 3);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, flush = 1'b0, cmd_ready = 1'b1;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_ready, cmd_valid, cmd_write, cmd_overhead;
   logic [2:0] cmd_bank, cmd_slot;
   logic [ROW_W-1:0] cmd_row;
   logic [COL_W-1:0] cmd_col;

   always #2 clk = ~clk;

   inline_ecc_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .flush(flush),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_overhead(cmd_overhead), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
      .cmd_col(cmd_col), .cmd_slot(cmd_slot)
   );

   int checks = 0, errs = 0, cycles = 0;
   bit rnd_mode = 1'b0, force_rdy = 1'b1, done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   int m_pend = 0, m_loaded = 0, m_kb = 0, m_kr = 0, m_kc = 0;
   int e_fire = 0, e_src = 0, e_pb = 0, e_pr = 0, e_pc = 0, e_wr = 0;

   function automatic void addr_split(input int a, output int db, output int dr, output int dc,
                                      output int pb, output int pr, output int pc, output int sl);
      int wc, b0, r, bh;
      wc = a % WCN;
      b0 = (a / WCN) % 2;
      r  = (a / (WCN * 2)) % (1 << ROW_W);
      bh = (a / (WCN * 2 * (1 << ROW_W))) % 4;
      db = bh * 2 + b0;
      dr = r;
      dc = wc * 8;
      pb = 6 + (1 - b0);
      pr = (1 << (ROW_W - 1)) + r / 2;
      pc = (r % 2) * (1 << (COL_W - 1)) + bh * (1 << (COL_W - 3)) + (wc / 8) * 8;
      sl = wc % 8;
   endfunction

   always @(negedge clk) begin
      int db, dr, dc, pb, pr, pc, sl;
      int wb, ld, same;
      int xv, xr, xw, xo, xb, xrw, xc, xs;
      addr_split(int'(req_addr), db, dr, dc, pb, pr, pc, sl);
      same = (m_kb == pb && m_kr == pr && m_kc == pc) ? 1 : 0;
      wb = (m_pend != 0 && (flush || (req_valid && (same == 0 || (!req_write && m_loaded == 0))))) ? 1 : 0;
      ld = (wb == 0 && req_valid && !req_write && !(m_loaded != 0 && same != 0)) ? 1 : 0;
      xv = (wb != 0 || ld != 0 || req_valid) ? 1 : 0;
      xr = (cmd_ready && wb == 0 && ld == 0) ? 1 : 0;
      if (wb != 0) begin xw = 1; xo = 1; xb = m_kb; xrw = m_kr; xc = m_kc; xs = 0; end
      else if (ld != 0) begin xw = 0; xo = 1; xb = pb; xrw = pr; xc = pc; xs = 0; end
      else begin xw = int'(req_write); xo = 0; xb = db; xrw = dr; xc = dc; xs = sl; end
      if (rst_n) begin
         chk(cmd_valid == xv[0] && req_ready == xr[0], "R9 R10 handshake stream",
             {cmd_valid, req_ready}, {xv[0], xr[0]});
         if (xv != 0)
            chk(cmd_write == xw[0] && cmd_overhead == xo[0] && cmd_bank == xb[2:0] &&
                cmd_row == xrw[ROW_W-1:0] && cmd_col == xc[COL_W-1:0] && cmd_slot == xs[2:0],
                "R11 command stream",
                {cmd_write, cmd_overhead, cmd_bank, cmd_row, cmd_col, cmd_slot},
                {xw[0], xo[0], xb[2:0], xrw[ROW_W-1:0], xc[COL_W-1:0], xs[2:0]});
      end
      e_fire = (xv != 0 && cmd_ready) ? 1 : 0;
      e_src  = (wb != 0) ? 1 : (ld != 0) ? 2 : 0;
      e_pb = pb; e_pr = pr; e_pc = pc; e_wr = int'(req_write);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_loaded = 0; m_kb = 0; m_kr = 0; m_kc = 0;
      end else if (e_fire != 0) begin
         if (e_src == 1) m_pend = 0;
         else if (e_src == 2) begin m_loaded = 1; m_kb = e_pb; m_kr = e_pr; m_kc = e_pc; end
         else if (e_wr != 0) begin
            if (!(m_kb == e_pb && m_kr == e_pr && m_kc == e_pc)) m_loaded = 0;
            m_pend = 1; m_kb = e_pb; m_kr = e_pr; m_kc = e_pc;
         end
      end
   end

   // ---------------- command log ----------------
   int lg_ov[$], lg_wr[$], lg_bank[$], lg_row[$], lg_col[$];
   always @(posedge clk) begin
      if (rst_n && cmd_valid && cmd_ready) begin
         lg_ov.push_back(int'(cmd_overhead));
         lg_wr.push_back(int'(cmd_write));
         lg_bank.push_back(int'(cmd_bank));
         lg_row.push_back(int'(cmd_row));
         lg_col.push_back(int'(cmd_col));
      end
   end

   task automatic clear_log();
      lg_ov.delete(); lg_wr.delete(); lg_bank.delete(); lg_row.delete(); lg_col.delete();
   endtask

   // ---------------- ready driver and watchdog ----------------
   logic [15:0] lfsr = 16'hACE1;
   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1 cmd_ready = rnd_mode ? (lfsr[0] | lfsr[3]) : force_rdy;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errs++; checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
         finish_run();
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic do_req(input bit wr, input int a);
      bit hs;
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = wr; req_addr = a[ADDR_W-1:0];
      forever begin
         @(negedge clk);
         hs = req_ready;
         @(posedge clk);
         if (hs) break;
      end
      #1 req_valid = 1'b0;
   endtask

   task automatic probe(input bit wr, input int a);
      @(posedge clk); #1;
      force_rdy = 1'b0; cmd_ready = 1'b0;
      req_valid = 1'b1; req_write = wr; req_addr = a[ADDR_W-1:0];
      @(negedge clk);
   endtask

   task automatic end_probe();
      #1 req_valid = 1'b0; force_rdy = 1'b1; cmd_ready = 1'b1;
   endtask

   int a_hi;

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R10 idle after reset cmd_valid", cmd_valid, 0);
      chk(req_ready == 1'b1, "R9 idle req_ready follows cmd_ready", req_ready, 1);

      // R1 / R4 data mapping probes
      probe(1'b1, 9);
      chk(cmd_bank == 0 && cmd_row == 0 && cmd_col == 72, "R1 word 9 to column 72",
          {cmd_bank, cmd_row, cmd_col}, {3'd0, 16'd0, 10'd72});
      chk(cmd_slot == 1 && !cmd_overhead, "R4 word 9 slot", {cmd_overhead, cmd_slot}, 1);
      end_probe();
      probe(1'b1, 128);
      chk(cmd_bank == 1 && cmd_row == 0 && cmd_col == 0, "R1 bank pair interleave",
          {cmd_bank, cmd_row, cmd_col}, {3'd1, 16'd0, 10'd0});
      end_probe();
      probe(1'b1, 256);
      chk(cmd_bank == 0 && cmd_row == 1, "R1 row after bank pair", {cmd_bank, cmd_row}, {3'd0, 16'd1});
      end_probe();
      a_hi = (3 << (ADDR_W - 2)) + 5;
      probe(1'b1, a_hi);
      chk(cmd_bank == 6 && cmd_col == 40, "R1 upper bank bits", {cmd_bank, cmd_col}, {3'd6, 10'd40});
      end_probe();

      // R2 / R3 / R4 parity mapping via first-read overhead (R10)
      probe(1'b0, 0);
      chk(cmd_overhead && !cmd_write, "R10 first read loads parity", {cmd_overhead, cmd_write}, 2'b10);
      chk(cmd_bank == 7 && cmd_row == 16'h8000 && cmd_col == 0, "R2 R3 parity of word 0",
          {cmd_bank, cmd_row, cmd_col}, {3'd7, 16'h8000, 10'd0});
      end_probe();
      probe(1'b0, 128);
      chk(cmd_bank == 6, "R2 odd bank parity in bank 6", cmd_bank, 6);
      end_probe();
      probe(1'b0, 256 + 8);
      chk(cmd_row == 16'h8000 && cmd_col == 520, "R4 row bit to parity column",
          {cmd_row, cmd_col}, {16'h8000, 10'd520});
      end_probe();
      probe(1'b0, (2 << (ADDR_W - 2)) + (3 << 8) + 20);
      chk(cmd_bank == 7 && cmd_row == 16'h8001 && cmd_col == 784, "R3 R4 mixed parity address",
          {cmd_bank, cmd_row, cmd_col}, {3'd7, 16'h8001, 10'd784});
      end_probe();

      // R5 sequential writes
      clear_log();
      for (int i = 0; i <= 8; i++) do_req(1'b1, i);
      @(posedge clk); #1;
      chk(lg_ov.size() == 10, "R5 sequential write command count", lg_ov.size(), 10);
      if (lg_ov.size() == 10) begin
         chk(lg_ov[0] == 0, "R10 first write has no write-back", lg_ov[0], 0);
         chk(lg_ov[8] == 1 && lg_wr[8] == 1 && lg_bank[8] == 7 && lg_row[8] == 32768 && lg_col[8] == 0,
             "R5 write-back of parity column 0", lg_col[8], 0);
         chk(lg_ov[9] == 0 && lg_col[9] == 64, "R5 user write follows write-back", lg_col[9], 64);
      end

      // R8 flush
      @(posedge clk); #1 flush = 1'b1;
      @(negedge clk);
      chk(cmd_valid && cmd_overhead && cmd_write && cmd_col == 8, "R8 flush writes back pending",
          {cmd_valid, cmd_overhead, cmd_write, cmd_col}, {3'b111, 10'd8});
      chk(req_ready == 1'b0, "R9 ready low during write-back", req_ready, 0);
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R8 flush with nothing pending is silent", cmd_valid, 0);
      #1 flush = 1'b0;

      // R6 sequential reads
      clear_log();
      for (int i = 0; i < 16; i++) do_req(1'b0, i);
      @(posedge clk); #1;
      chk(lg_ov.size() == 18, "R6 sequential read command count", lg_ov.size(), 18);
      if (lg_ov.size() == 18) begin
         chk(lg_ov[0] == 1 && lg_wr[0] == 0 && lg_col[0] == 0 && lg_bank[0] == 7,
             "R6 load precedes first read", lg_ov[0], 1);
         chk(lg_ov[9] == 1 && lg_wr[9] == 0 && lg_col[9] == 8, "R6 second load at column 8", lg_col[9], 8);
         chk(lg_ov[1] == 0 && lg_col[1] == 0, "R6 data read after load", lg_col[1], 0);
      end

      // R7 read of a pending, unloaded parity word
      clear_log();
      do_req(1'b1, 16);
      do_req(1'b0, 16);
      @(posedge clk); #1;
      chk(lg_ov.size() == 4, "R7 command count", lg_ov.size(), 4);
      if (lg_ov.size() == 4) begin
         chk(lg_ov[1] == 1 && lg_wr[1] == 1 && lg_col[1] == 16, "R7 write-back first", lg_wr[1], 1);
         chk(lg_ov[2] == 1 && lg_wr[2] == 0 && lg_col[2] == 16, "R7 then reload", lg_wr[2], 0);
         chk(lg_ov[3] == 0 && lg_wr[3] == 0, "R7 then data read", lg_ov[3], 0);
      end

      // mixed traffic with stalls, compared by the model every cycle (R11)
      rnd_mode = 1'b1;
      begin
         int a = 0;
         for (int n = 0; n < 1500; n++) begin
            if (($urandom % 10) == 0) a = $urandom % (1 << ADDR_W);
            else a = (a + 1) % (1 << ADDR_W);
            if (($urandom % 25) == 0) begin
               @(posedge clk); #1 flush = 1'b1;
               @(posedge clk); #1 flush = 1'b0;
            end
            do_req(($urandom % 3) != 0, a);
         end
      end
      rnd_mode = 1'b0;
      repeat (5) @(posedge clk);
      finish_run();
   end
endmodule